// File: doc/BRIEF.md
# Power-Switch Fault Override Controller

This block owns the two pins that face an external power switch: an enable output that turns the switch on and a fault input that the switch raises when it detects trouble. Software sets the enable pin through a control register. A hardware path can also take the pin over when the switch reports a fault, so the response does not wait for firmware. The fault input is synchronized to the block clock. It is qualified by an input-enable bit and by a polarity bit, and a qualified fault is latched in a sticky flag.

While automatic action is enabled and a fault is present or latched, the pin is forced to one of four programmed states: left under software control, released (not driven), driven low or driven high. The pin leaves the block as a level plus an output-enable, so the pad can tristate it. Register access is a plain single-cycle port. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr` while `bus_sel` is high. This port has no back-pressure: every access completes in the cycle it is presented.

Top module: `pwr_fault_ctl`

## Requirements
- R1: After reset, every writable control field is 0, the fault flag is 0, and both `pin_oe` and `pin_out` are 0.
- R2: The control register is at offset 0x400 and reads back only its writable fields: action in bits 9:8, automatic-action enable in bit 6, polarity in bit 5, input enable in bit 4, drive enable in bit 1 and drive level in bit 0. Writing all ones reads back 0x373. All other bits read 0 and ignore writes.
- R3: When no override applies, `pin_oe` equals control bit 1 and `pin_out` equals control bit 0.
- R4: Polarity bit 5 = 1 makes a high level on `fault_in` a fault, and bit 5 = 0 makes a low level a fault. The opposite level is inactive and raises no fault.
- R5: With input enable (bit 4) = 0, `fault_in` is ignored: the flag stays 0 and the pin follows software.
- R6: With automatic-action enable (bit 6) = 0, the pin follows software even while a fault is present. A qualified fault still sets the flag.
- R7: Under override, the action code selects the pin state. Code 0 gives software control. Code 1 gives `pin_oe`=0 and `pin_out`=0. Code 2 gives `pin_oe`=1 and `pin_out`=0. Code 3 gives `pin_oe`=1 and `pin_out`=1.
- R8: `fault_in` passes through a two-stage synchronizer. The override appears after the second rising clock edge following the change, and not after the first.
- R9: A qualified fault sets a sticky flag, read at bit 0 of offset 0x404. The override persists while the flag is set, even after `fault_in` becomes inactive. Writing 1 to bit 0 clears the flag, and writing 0 does not. If the fault is still active, the flag stays set.
- R10: Writing the action or enable fields while the flag is set changes the pin state on the next clock, without clearing the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, 0 when not selected |
| fault_in | input | 1 | Asynchronous fault input from the power switch |
| pin_out | output | 1 | Enable pin level |
| pin_oe | output | 1 | Enable pin output-enable |

## Verification
The hardest situation to reach is a latched fault after `fault_in` has already gone inactive. In that state only the sticky flag holds the override, so a flag that failed to latch would go unnoticed from the pins while the fault is still present. The bench reaches it by first raising a fault with automatic action disabled, which latches the flag while the pin stays under software control. It then removes the fault and enables automatic action, so any override that appears must come from the flag. It then rewrites the action code and the enables with the flag still set, and checks that each write reaches the pin one clock later.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  localparam int unsigned CTRL_OFS = 32'h400;
  localparam int unsigned STAT_OFS = 32'h404;

  typedef enum logic [1:0] {
    ACT_KEEP  = 2'd0,
    ACT_FLOAT = 2'd1,
    ACT_LOW   = 2'd2,
    ACT_HIGH  = 2'd3
  } fault_act_e;

  typedef struct packed {
    fault_act_e action;
    logic       auto_en;
    logic       hi_sense;
    logic       in_en;
    logic       drv_en;
    logic       drv_lvl;
  } ctrl_t;

endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d_async;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pfc_fault.sv
module pfc_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_s,
  input  logic in_en,
  input  logic hi_sense,
  input  logic flag_clr,
  output logic qual,
  output logic flag
);
  assign qual = in_en & (fault_s == hi_sense);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        flag <= 1'b0;
    else if (qual)     flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;

  // R9: a set flag survives unless a clear is written
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);
  // R9: a qualified fault always leaves the flag set
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> flag);
  // R5: a disabled input cannot raise the flag
  p_in_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !in_en) |=> !flag);
endmodule

// File: rtl/pfc_regs.sv
module pfc_regs
  import pfc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              flag,
  output ctrl_t             ctrl,
  output logic              flag_clr
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

  logic hit_ctrl, hit_stat, unused_wbits;

  assign hit_ctrl = bus_sel && (bus_addr == A_CTRL);
  assign hit_stat = bus_sel && (bus_addr == A_STAT);
  assign flag_clr = hit_stat && bus_wr && bus_wdata[0];
  assign unused_wbits = ^{bus_wdata[DATA_W-1:10], bus_wdata[7], bus_wdata[3:2]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl <= '0;
    else if (hit_ctrl && bus_wr) begin
      ctrl.action   <= fault_act_e'(bus_wdata[9:8]);
      ctrl.auto_en  <= bus_wdata[6];
      ctrl.hi_sense <= bus_wdata[5];
      ctrl.in_en    <= bus_wdata[4];
      ctrl.drv_en   <= bus_wdata[1];
      ctrl.drv_lvl  <= bus_wdata[0];
    end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl) begin
      bus_rdata[9:8] = ctrl.action;
      bus_rdata[6]   = ctrl.auto_en;
      bus_rdata[5]   = ctrl.hi_sense;
      bus_rdata[4]   = ctrl.in_en;
      bus_rdata[1]   = ctrl.drv_en;
      bus_rdata[0]   = ctrl.drv_lvl;
    end else if (hit_stat) begin
      bus_rdata[0] = flag;
    end
  end

  // R2: reserved upper bits never read back as 1
  p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctrl |-> (bus_rdata[DATA_W-1:10] == '0 && bus_rdata[7] == 1'b0));
  // R10: a control write lands on the next clock
  p_ctrl_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ctrl && bus_wr) |=> (ctrl.auto_en == $past(bus_wdata[6])));
endmodule

// File: rtl/pfc_drive.sv
module pfc_drive
  import pfc_pkg::*;
(
  input  ctrl_t ctrl,
  input  logic  fault_on,
  output logic  pin_out,
  output logic  pin_oe
);
  logic take_over;
  assign take_over = ctrl.auto_en & fault_on;

  always_comb begin
    pin_oe  = ctrl.drv_en;
    pin_out = ctrl.drv_lvl;
    if (take_over) begin
      unique case (ctrl.action)
        ACT_KEEP:  ;
        ACT_FLOAT: begin pin_oe = 1'b0; pin_out = 1'b0; end
        ACT_LOW:   begin pin_oe = 1'b1; pin_out = 1'b0; end
        ACT_HIGH:  begin pin_oe = 1'b1; pin_out = 1'b1; end
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/pwr_fault_ctl.sv
module pwr_fault_ctl
  import pfc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              fault_in,
  output logic              pin_out,
  output logic              pin_oe
);
  ctrl_t ctrl;
  logic  fault_s, qual, flag, flag_clr;

  pfc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flag(flag), .ctrl(ctrl), .flag_clr(flag_clr)
  );

  pfc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(fault_in), .q_sync(fault_s)
  );

  pfc_fault u_fault (
    .clk(clk), .rst_n(rst_n), .fault_s(fault_s), .in_en(ctrl.in_en),
    .hi_sense(ctrl.hi_sense), .flag_clr(flag_clr), .qual(qual), .flag(flag)
  );

  pfc_drive u_drive (
    .ctrl(ctrl), .fault_on(qual | flag), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // R6: automatic action off means the pin follows software
  p_auto_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.auto_en |-> (pin_oe == ctrl.drv_en && pin_out == ctrl.drv_lvl));
  // R9: with a latched flag and action 3 the pin is held high
  p_hold_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && ctrl.auto_en && ctrl.action == ACT_HIGH) |-> (pin_oe && pin_out));
  // R7: a released pin is never driven
  p_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && ctrl.auto_en && ctrl.action == ACT_FLOAT) |-> !pin_oe);
endmodule

// File: tb/sim_pwr_fault_ctl.sv
`timescale 1ns/1ps
module sim_pwr_fault_ctl;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fault_in = 1'b0;
  logic        pin_out, pin_oe;

  int n_tests = 0;
  int n_fail  = 0;

  always #(HALF) clk = ~clk;

  pwr_fault_ctl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fault_in(fault_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic [1:0] pin();
    return {pin_oe, pin_out};
  endfunction

  // return to a quiet state: fault pin at level, flag cleared
  task automatic quiet(input logic lvl, input logic [31:0] c);
    fault_in = lvl;
    wr(12'h400, c);
    tick(3);
    wr(12'h404, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pin", {30'd0, pin()}, 32'h0);
    rd(12'h400, d); chk("R1 ctrl", d, 32'h0);
    rd(12'h404, d); chk("R1 flag", d, 32'h0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    fault_in = 1'b0;
    wr(12'h400, 32'hFFFF_FFFF);
    rd(12'h400, d); chk("R2 readback", d, 32'h373);
    wr(12'h400, 32'h0);
    rd(12'h400, d); chk("R2 cleared", d, 32'h0);
  endtask

  task automatic t_soft();
    wr(12'h400, 32'h3); chk("R3 oe1 lvl1", pin(), 2'b11);
    wr(12'h400, 32'h2); chk("R3 oe1 lvl0", pin(), 2'b10);
    wr(12'h400, 32'h1); chk("R3 oe0 lvl1", pin(), 2'b01);
  endtask

  task automatic t_actions();
    logic [1:0] exp [4];
    exp[0] = 2'b10; exp[1] = 2'b00; exp[2] = 2'b10; exp[3] = 2'b11;
    for (int a = 0; a < 4; a++) begin
      quiet(1'b0, 32'h70 | 32'h2);
      wr(12'h400, (a << 8) | 32'h70 | 32'h2);
      fault_in = 1'b1;
      tick(3);
      chk($sformatf("R7 action %0d", a), pin(), exp[a]);
    end
    quiet(1'b0, 32'h0);
  endtask

  task automatic t_polarity();
    logic [31:0] d;
    quiet(1'b1, 32'h0);
    wr(12'h400, 32'h350);
    tick(3);
    rd(12'h404, d); chk("R4 low-active idle flag", d, 32'h0);
    chk("R4 low-active idle pin", pin(), 2'b00);
    fault_in = 1'b0;
    tick(3);
    chk("R4 low-active fault pin", pin(), 2'b11);
    quiet(1'b0, 32'h370);
    tick(3);
    rd(12'h404, d); chk("R4 high-active idle flag", d, 32'h0);
    chk("R4 high-active idle pin", pin(), 2'b00);
    quiet(1'b0, 32'h0);
  endtask

  task automatic t_latency();
    quiet(1'b0, 32'h370);
    fault_in = 1'b1;
    tick(1); chk("R8 one edge", pin(), 2'b00);
    tick(1); chk("R8 two edges", pin(), 2'b11);
    quiet(1'b0, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    quiet(1'b0, 32'h272);
    fault_in = 1'b1; tick(3);
    fault_in = 1'b0; tick(4);
    chk("R9 hold after release", pin(), 2'b10);
    rd(12'h404, d); chk("R9 flag held", d, 32'h1);
    wr(12'h404, 32'h0);
    rd(12'h404, d); chk("R9 write 0 keeps flag", d, 32'h1);
    wr(12'h404, 32'h1);
    rd(12'h404, d); chk("R9 write 1 clears", d, 32'h0);
    chk("R9 pin back to software", pin(), 2'b10);
    wr(12'h400, 32'h271);
    fault_in = 1'b1; tick(3);
    wr(12'h404, 32'h1);
    rd(12'h404, d); chk("R9 clear while active", d, 32'h1);
    quiet(1'b0, 32'h0);
  endtask

  task automatic t_in_off();
    logic [31:0] d;
    quiet(1'b0, 32'h0);
    wr(12'h400, 32'h360);
    fault_in = 1'b1; tick(4);
    rd(12'h404, d); chk("R5 flag stays 0", d, 32'h0);
    chk("R5 pin software", pin(), 2'b00);
    quiet(1'b0, 32'h0);
  endtask

  task automatic t_auto_off();
    logic [31:0] d;
    quiet(1'b0, 32'h0);
    wr(12'h400, 32'h331);
    fault_in = 1'b1; tick(4);
    chk("R6 pin follows software", pin(), 2'b01);
    rd(12'h404, d); chk("R6 flag latched", d, 32'h1);
    fault_in = 1'b0; tick(3);
    wr(12'h400, 32'h371);
    chk("R10 enable under latch", pin(), 2'b11);
    wr(12'h400, 32'h171);
    chk("R10 change action", pin(), 2'b00);
    wr(12'h400, 32'h131);
    chk("R10 release", pin(), 2'b01);
    rd(12'h404, d); chk("R10 flag untouched", d, 32'h1);
    quiet(1'b0, 32'h0);
  endtask

  initial begin
    #(HALF * 2 * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_reserved();
    t_soft();
    t_actions();
    t_polarity();
    t_latency();
    t_sticky();
    t_in_off();
    t_auto_off();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule